// File: doc/BRIEF.md
# Cascaded Configurable Interrupt Controller

The block gathers 96 interrupt sources into a single request line to the processor. The sources are split into three banks of 32. The main bank holds sources 0 to 31. Sub-bank 1 holds sources 32 to 63, and sub-bank 2 holds sources 64 to 95. Within a bank, the bit index of a source is its number minus the bank base.

Each source has two configuration bits, one for polarity and one for activation type. Together they choose active-high level, active-low level, rising edge or falling edge. Sources set to edge are held in a latch until software writes a one to clear them. Sources set to level show their live state. Each bank ANDs its raw status with its own enable word.

Each sub-bank combines its enabled sources into one line. That line is fed into a reserved slot of the main bank, so the main bank can condition and enable the cascade like any other source.

Software reaches the registers through a simple write port and a combinational read port. Each port uses a 5-bit address made of the bank number and a register code.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Address = {bank[1:0], reg[2:0]}. Bank codes: 0 main, 1 sub-bank 1, 2 sub-bank 2. Register codes:
  - 0 enable
  - 1 polarity
  - 2 type
  - 3 raw status
  - 4 masked status

  `src_i[n]` is source n, and it sits at bit n-32·bank of its bank.
- R2: After reset every enable word is 0 and `irq_o` is low. The polarity words are 0x3FF0EFE0 (main), 0xFBD27186 (sub 1) and 0x801810C0 (sub 2). The type words are 0, except sub-bank 1, which is 0x00026000.
- R3: A type bit of 0 selects level sensitivity. Raw status then follows the input through a two-flop synchroniser, so a change is visible after two rising clock edges. Polarity 1 means active-high and polarity 0 means active-low.
- R4: A type bit of 1 selects edge sensitivity. Polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. The opposite edge is ignored. The raw bit sets on the third rising clock edge after the input changes, and it stays set after the input returns.
- R5: Writing a 1 to a raw status bit clears a latched edge. Writing a 0 leaves the bit unchanged. A clear written to a level source has no effect.
- R6: If a new active edge is detected in the same cycle as a clear of that bit, the bit stays latched.
- R7: Masked status reads as raw status AND enable. An enable bit of 0 keeps that source away from the request line.
- R8: The OR of sub-bank 1's masked status drives main-bank slot 0, and sub-bank 2's drives slot 1. Both are driven active-low, so the default level-low polarity sees them as asserted.
- R9: `irq_o` is the OR of the main bank's masked status, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | 96 | Raw interrupt sources, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address {bank, reg} |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read address {bank, reg} |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Request line to the processor |

## Verification
The assertions check four properties on every cycle:
- the request line is low whenever the main enable word is zero;
- a latched edge survives any cycle without a clear;
- a clear with no coincident edge empties the latch;
- the sub-bank 1 cascade slot tracks that bank's combined output while it is set to level-low.

The reset words, the synchroniser latency and the polarity and edge choices are shown only by the bench's scenarios. So are the clear that collides with a new edge, and the end-to-end path from a sub-bank source to the request line.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int          SUB1_SLOT    = 0,
  parameter int          SUB2_SLOT    = 1,
  parameter logic [31:0] MAIN_POL_RST = 32'h3FF0EFE0,
  parameter logic [31:0] SUB1_POL_RST = 32'hFBD27186,
  parameter logic [31:0] SUB2_POL_RST = 32'h801810C0,
  parameter logic [31:0] MAIN_TYP_RST = 32'h00000000,
  parameter logic [31:0] SUB1_TYP_RST = 32'h00026000,
  parameter logic [31:0] SUB2_TYP_RST = 32'h00000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [95:0] src_i,
  input  logic        wr_en_i,
  input  logic [4:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [4:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  localparam logic [2:0] REG_EN = 3'd0, REG_POL = 3'd1, REG_TYP = 3'd2,
                         REG_RAW = 3'd3, REG_STAT = 3'd4;

  logic [95:0]      sync1_q, sync2_q;
  logic [2:0][31:0] en_q, pol_q, typ_q, edge_q, prev_q;
  logic [2:0][31:0] cur_a, hit_v, clr_v;
  logic [31:0]      raw0, raw1, raw2, main_in, rd_raw;
  logic             sub1_any, sub2_any;

  function automatic logic [31:0] raw_f(input logic [31:0] cur, pol, typ, edg);
    return (typ & edg) | (~typ & ~(cur ^ pol));
  endfunction

  function automatic logic [31:0] hit_f(input logic [31:0] cur, prv, pol);
    return (pol & cur & ~prv) | (~pol & ~cur & prv);
  endfunction

  assign raw1     = raw_f(sync2_q[63:32], pol_q[1], typ_q[1], edge_q[1]);
  assign raw2     = raw_f(sync2_q[95:64], pol_q[2], typ_q[2], edge_q[2]);
  assign sub1_any = |(raw1 & en_q[1]);
  assign sub2_any = |(raw2 & en_q[2]);

  always_comb begin
    main_in            = sync2_q[31:0];
    main_in[SUB1_SLOT] = ~sub1_any;
    main_in[SUB2_SLOT] = ~sub2_any;
  end

  assign raw0  = raw_f(main_in, pol_q[0], typ_q[0], edge_q[0]);
  assign irq_o = |(raw0 & en_q[0]);
  assign cur_a = {sync2_q[95:64], sync2_q[63:32], main_in};

  always_comb begin
    for (int b = 0; b < 3; b++) begin
      hit_v[b] = typ_q[b] & hit_f(cur_a[b], prev_q[b], pol_q[b]);
      clr_v[b] = (wr_en_i && wr_addr_i[4:3] == 2'(b) && wr_addr_i[2:0] == REG_RAW)
                 ? wr_data_i : 32'h0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      edge_q  <= '0;
      en_q    <= '0;
      pol_q   <= {SUB2_POL_RST, SUB1_POL_RST, MAIN_POL_RST};
      typ_q   <= {SUB2_TYP_RST, SUB1_TYP_RST, MAIN_TYP_RST};
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= cur_a;
      for (int b = 0; b < 3; b++) begin
        edge_q[b] <= typ_q[b] & (hit_v[b] | (edge_q[b] & ~clr_v[b]));
        if (wr_en_i && wr_addr_i[4:3] == 2'(b)) begin
          case (wr_addr_i[2:0])
            REG_EN:  en_q[b]  <= wr_data_i;
            REG_POL: pol_q[b] <= wr_data_i;
            REG_TYP: typ_q[b] <= wr_data_i;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (rd_addr_i[4:3])
      2'd0:    rd_raw = raw0;
      2'd1:    rd_raw = raw1;
      2'd2:    rd_raw = raw2;
      default: rd_raw = 32'h0;
    endcase
    rd_data_o = 32'h0;
    if (rd_addr_i[4:3] != 2'd3) begin
      case (rd_addr_i[2:0])
        REG_EN:   rd_data_o = en_q[rd_addr_i[4:3]];
        REG_POL:  rd_data_o = pol_q[rd_addr_i[4:3]];
        REG_TYP:  rd_data_o = typ_q[rd_addr_i[4:3]];
        REG_RAW:  rd_data_o = rd_raw;
        REG_STAT: rd_data_o = rd_raw & en_q[rd_addr_i[4:3]];
        default:  rd_data_o = 32'h0;
      endcase
    end
  end

  a_r9_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[0] == 32'h0) |-> !irq_o);

  a_r8_sub1_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!typ_q[0][SUB1_SLOT] && !pol_q[0][SUB1_SLOT]) |-> (raw0[SUB1_SLOT] == (|(raw1 & en_q[1]))));

  for (genvar g = 0; g < 3; g++) begin : g_chk
    a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (($past(edge_q[g] & typ_q[g] & ~clr_v[g]) & typ_q[g] & ~edge_q[g]) == 32'h0));
    a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (($past(clr_v[g] & ~hit_v[g]) & edge_q[g]) == 32'h0));
  end
endmodule

// File: tb/cascade_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic [95:0] src = '0;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cascade_irq_ctrl u_cascade_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq));

  function automatic logic [4:0] adr(input int bank, input int rg);
    return {2'(bank), 3'(rg)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int bank, input int rg, input logic [31:0] d);
    wr_addr = adr(bank, rg); wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int bank, input int rg, output logic [31:0] d);
    rd_addr = adr(bank, rg); #1; d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, 1, d); check("R2 main pol", d, 32'h3FF0EFE0);
    rd(1, 1, d); check("R2 sub1 pol", d, 32'hFBD27186);
    rd(2, 1, d); check("R2 sub2 pol", d, 32'h801810C0);
    rd(1, 2, d); check("R2 sub1 type", d, 32'h00026000);
    rd(0, 2, d); check("R2 main type", d, 32'h0);
    for (int b = 0; b < 3; b++) begin rd(b, 0, d); check("R2 enable zero", d, 32'h0); end
    check("R2 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(0, 0, 32'h20);
    check("R3 idle low", 32'(irq), 0);
    src[5] = 1; step(1);
    check("R3 sync latency", 32'(irq), 0);
    step(1);
    check("R3 active-high seen", 32'(irq), 1);
    rd(0, 4, d); check("R7 R1 masked status bit5", d & 32'h20, 32'h20);
    wr(0, 3, 32'h20);
    rd(0, 3, d); check("R5 level clear ignored", d & 32'h20, 32'h20);
    src[5] = 0; step(2);
    check("R3 released", 32'(irq), 0);
    wr(0, 1, 32'h3FF0EFE0 & ~32'h20);
    check("R3 active-low seen", 32'(irq), 1);
    wr(0, 1, 32'h3FF0EFE0);
    wr(0, 0, 32'h0);
  endtask

  task automatic t_rise_sub2;
    logic [31:0] d;
    wr(2, 1, 32'h801810C0 | 32'h8);
    wr(2, 2, 32'h8);
    wr(2, 0, 32'h8);
    wr(0, 0, 32'h2);
    check("R4 no edge yet", 32'(irq), 0);
    src[67] = 1; step(1);
    src[67] = 0; step(2);
    rd(2, 3, d); check("R4 rising latched", d & 32'h8, 32'h8);
    check("R8 R9 sub2 cascade irq", 32'(irq), 1);
    rd(0, 3, d); check("R8 main slot1", d & 32'h3, 32'h2);
    wr(2, 3, 32'h0);
    rd(2, 3, d); check("R5 zero write keeps", d & 32'h8, 32'h8);
    wr(0, 0, 32'h0);
    check("R7 main mask blocks", 32'(irq), 0);
    rd(0, 4, d); check("R7 masked status zero", d, 32'h0);
    wr(0, 0, 32'h2);
    wr(2, 3, 32'h8);
    rd(2, 3, d); check("R5 edge cleared", d & 32'h8, 32'h0);
    check("R5 irq dropped", 32'(irq), 0);
    wr(0, 0, 32'h0); wr(2, 0, 32'h0);
  endtask

  task automatic t_fall_sub1;
    logic [31:0] d;
    wr(1, 1, 32'hFBD27186 & ~32'h2000);
    wr(1, 0, 32'h2000);
    wr(0, 0, 32'h1);
    src[45] = 1; step(4);
    rd(1, 3, d); check("R4 rising ignored on falling", d & 32'h2000, 32'h0);
    src[45] = 0; step(3);
    rd(1, 3, d); check("R4 falling latched", d & 32'h2000, 32'h2000);
    check("R8 sub1 cascade irq", 32'(irq), 1);
    src[45] = 1; step(4);
    src[45] = 0; step(2);
    wr(1, 3, 32'h2000);
    rd(1, 3, d); check("R6 collision keeps latch", d & 32'h2000, 32'h2000);
    step(2);
    wr(1, 3, 32'h2000);
    rd(1, 3, d); check("R5 plain clear", d & 32'h2000, 32'h0);
    check("R9 irq low after clear", 32'(irq), 0);
  endtask

  initial begin
    fork
      begin
        step(3); rst_n = 1; step(1);
        t_reset();
        t_level();
        t_rise_sub2();
        t_fall_sub1();
      end
      begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog: run hung");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule